// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block is the transmit side of a serial controller that a processor programs over a byte-wide register interface. After reset the first byte written with the control select high is the mode byte. It fixes the character length, the parity, the stop-bit length and how many transmit-clock ticks make up one bit. Every later control write is a command. A command enables the transmitter, drives the DTR and RTS outputs, forces a break, or returns the block to its post-reset state so that a new mode byte can be written.

The processor writes a character into a one-byte holding register and polls a status byte to see when the next character can be written. The transmit clock arrives as a one-cycle tick strobe in the system clock domain, at 1, 16 or 64 ticks per bit. On a tick, the shifter takes the held character and sends a low start bit, the data bits least significant first, an optional parity bit and a high stop period. The line then returns to high idle. If another character is waiting, the shifter starts it on the same tick that ends the stop period.

Top module: `async_tx_port`

## Requirements
- R1: After reset, or after a command with bit 6 set, the next control write (sel, wr_stb and ctl_sel high) is stored as the mode byte. Every later control write is a command. The internal-reset command clears all command bits and any pending or active character.
- R2: Mode bits 1:0 set the ticks per bit: 01 gives 1, 10 gives 16 and 11 gives 64. The code 00 is treated as 1.
- R3: Mode bits 3:2 set the character length: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8. Only that many low data bits are sent.
- R4: Mode bit 4 enables a parity bit after the data. Mode bit 5 selects even parity when 1 and odd parity when 0, computed over the data bits that are sent.
- R5: Mode bits 7:6 set the stop period. 01 (and 00) is 1 bit time, 10 is 1.5 bit times (2 ticks at 1 tick per bit) and 11 is 2 bit times.
- R6: A frame is a low start bit, then the data LSB first, then the parity bit if enabled, then the high stop period. The line is high when idle. The start bit begins on the first tick after a character is waiting.
- R7: A status read (sel, rd_stb and ctl_sel high) returns bit 0 = TxRDY, bit 2 = TxEMPTY and 0 in all other bits. TxRDY is high only when the holding register is empty and transmit enable (command bit 0) is set. A data write clears TxRDY.
- R8: TxEMPTY is high only when the holding register is empty and no frame is being shifted. It stays low until the tick that ends the stop period.
- R9: While command bit 3 (send break) is set, txd is held low.
- R10: Command bit 1 drives dtr_o and command bit 5 drives rts_o.
- R11: A held character is not started while transmit enable is clear.
- R12: A character that is waiting when a stop period ends starts its start bit on that same tick, with no idle bit between the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Chip select, active high |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high, one cycle per write |
| ctl_sel | input | 1 | High selects mode/command/status, low selects data |
| din | input | 8 | Write data bus |
| dout | output | 8 | Read data bus (status byte, else 0) |
| tck | input | 1 | Transmit clock tick, one cycle wide |
| txd | output | 1 | Serial output, idles high |
| rts_o | output | 1 | Request-to-send pass-through |
| dtr_o | output | 1 | Data-terminal-ready pass-through |
| txrdy | output | 1 | Holding register can take a character |
| txempty | output | 1 | Holding and shift registers both idle |

## Verification
A register write takes effect at the clock edge inside the write strobe. The status byte and dtr_o/rts_o are therefore checked at the next falling edge, and the status is read combinationally with no clock edge between driving the strobe and sampling. txd is registered on each tick, so the bench drives tck for exactly one clock and samples txd at the falling edge after it. Tick k of a frame is compared against the value worked out arithmetically for tick k: its bit index is k divided by the ticks per bit, and the stop period ends on tick F·(1+n+p)+S. TxEMPTY is checked both one tick before and right after that tick.

// File: rtl/async_tx_port.sv
module async_tx_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       rd_stb,
  input  logic       wr_stb,
  input  logic       ctl_sel,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic       tck,
  output logic       txd,
  output logic       rts_o,
  output logic       dtr_o,
  output logic       txrdy,
  output logic       txempty
);

  logic       mode_ok;
  logic [7:0] mode_q;
  logic       ten, brk;
  logic       hold_full;
  logic [7:0] hold_q;
  logic       busy, in_stop, txd_q;
  logic [8:0] shreg;
  logic [3:0] nleft;
  logic [7:0] cnt;

  wire ctl_wr  = sel & wr_stb & ctl_sel;
  wire dat_wr  = sel & wr_stb & ~ctl_sel;
  wire int_rst = ctl_wr & mode_ok & din[6];

  wire [1:0] fsel       = mode_q[1:0];
  wire [7:0] bit_ticks  = (fsel == 2'b11) ? 8'd64 : (fsel == 2'b10) ? 8'd16 : 8'd1;
  wire [7:0] half_ticks = fsel[1] ? (bit_ticks + (bit_ticks >> 1)) : 8'd2;
  wire [7:0] stop_ticks = (mode_q[7:6] == 2'b11) ? (bit_ticks << 1) :
                          (mode_q[7:6] == 2'b10) ? half_ticks : bit_ticks;
  wire [3:0] nbits      = 4'd5 + {2'b00, mode_q[3:2]};
  wire [7:0] dmask      = 8'hFF >> (3'd3 - {1'b0, mode_q[3:2]});
  wire [7:0] dmasked    = hold_q & dmask;
  wire       par_bit    = (^dmasked) ^ ~mode_q[5];
  wire [8:0] frame_bits = {1'b0, dmasked} | ({8'd0, par_bit & mode_q[4]} << nbits);

  wire frame_done = busy & in_stop & (cnt == 8'd0);
  wire load       = tck & mode_ok & ten & hold_full & (~busy | frame_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_ok <= 1'b0;
      mode_q  <= 8'd0;
      ten     <= 1'b0;
      brk     <= 1'b0;
      dtr_o   <= 1'b0;
      rts_o   <= 1'b0;
    end else if (ctl_wr) begin
      if (!mode_ok) begin
        mode_q  <= din;
        mode_ok <= 1'b1;
      end else if (din[6]) begin
        mode_ok <= 1'b0;
        ten     <= 1'b0;
        brk     <= 1'b0;
        dtr_o   <= 1'b0;
        rts_o   <= 1'b0;
      end else begin
        ten   <= din[0];
        dtr_o <= din[1];
        brk   <= din[3];
        rts_o <= din[5];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || int_rst) begin
      hold_full <= 1'b0;
      hold_q    <= 8'd0;
    end else if (dat_wr) begin
      hold_full <= 1'b1;
      hold_q    <= din;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || int_rst) begin
      busy    <= 1'b0;
      in_stop <= 1'b0;
      txd_q   <= 1'b1;
      cnt     <= 8'd0;
      shreg   <= 9'd0;
      nleft   <= 4'd0;
    end else if (tck) begin
      if (load) begin
        busy    <= 1'b1;
        in_stop <= 1'b0;
        txd_q   <= 1'b0;
        cnt     <= bit_ticks - 8'd1;
        shreg   <= frame_bits;
        nleft   <= nbits + {3'b000, mode_q[4]};
      end else if (frame_done) begin
        busy    <= 1'b0;
        in_stop <= 1'b0;
      end else if (busy) begin
        if (cnt != 8'd0) begin
          cnt <= cnt - 8'd1;
        end else if (nleft != 4'd0) begin
          txd_q <= shreg[0];
          shreg <= shreg >> 1;
          nleft <= nleft - 4'd1;
          cnt   <= bit_ticks - 8'd1;
        end else begin
          txd_q   <= 1'b1;
          in_stop <= 1'b1;
          cnt     <= stop_ticks - 8'd1;
        end
      end
    end
  end

  assign txd     = txd_q & ~brk;
  assign txrdy   = ~hold_full & ten;
  assign txempty = ~hold_full & ~busy;
  assign dout    = (sel & rd_stb & ctl_sel) ? {5'd0, txempty, 1'b0, txrdy} : 8'd0;

  assert_wr_clears_rdy_R7: assert property (@(posedge clk) disable iff (rst)
    dat_wr |=> !txrdy);

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !brk) |-> txd);

  assert_empty_line_high_R8: assert property (@(posedge clk) disable iff (rst)
    (txempty && !brk) |-> txd);

  assert_break_low_R9: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && mode_ok && din[3] && !din[6]) |=> !txd);

  assert_start_low_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd_q);

  assert_enable_gate_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ten));

endmodule

// File: tb/sim_async_tx_port.sv
`timescale 1ns/1ps
module sim_async_tx_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, ctl_sel = 1'b0, tck = 1'b0;
  logic [7:0] din = 8'd0;
  logic [7:0] dout;
  logic txd, rts_o, dtr_o, txrdy, txempty;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  async_tx_port u0 (
    .clk(clk), .rst(rst), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .ctl_sel(ctl_sel), .din(din), .dout(dout), .tck(tck), .txd(txd),
    .rts_o(rts_o), .dtr_o(dtr_o), .txrdy(txrdy), .txempty(txempty));

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ctl, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr_stb = 1'b1; ctl_sel = ctl; din = d;
    @(negedge clk);
    sel = 1'b0; wr_stb = 1'b0; ctl_sel = 1'b0;
  endtask

  task automatic rd_st(output logic [7:0] v);
    @(negedge clk);
    sel = 1'b1; rd_stb = 1'b1; ctl_sel = 1'b1;
    #1 v = dout;
    sel = 1'b0; rd_stb = 1'b0; ctl_sel = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tck = 1'b1;
    @(negedge clk);
    tck = 1'b0;
  endtask

  function automatic logic exp_bit(input int i, input int f, input int n, input int pe,
                                   input logic par, input logic [7:0] d);
    int b;
    b = i / f;
    if (b == 0) return 1'b0;
    if (b <= n) return d[b-1];
    if (pe != 0 && b == n + 1) return par;
    return 1'b1;
  endfunction

  task automatic run_frame(input int fs, input int len, input int pm, input int st,
                           input logic [7:0] d);
    logic [7:0] mode, s;
    int f, n, pe, sticks, total, ones, bad_i;
    logic par, got, exp, bad_got, bad_exp;
    f  = (fs == 3) ? 64 : (fs == 2) ? 16 : 1;
    n  = 5 + len;
    pe = (pm != 0) ? 1 : 0;
    sticks = (st == 3) ? 2 * f : (st == 2) ? ((f == 1) ? 2 : f + f / 2) : f;
    total = f * (1 + n + pe) + sticks;
    ones = 0;
    for (int k = 0; k < n; k++) ones += d[k];
    par = (pm == 2) ? logic'(ones % 2) : logic'(1 - ones % 2);
    mode = {st[1:0], (pm == 2) ? 1'b1 : 1'b0, pe[0], len[1:0], fs[1:0]};
    wr(1'b1, 8'h40);
    wr(1'b1, mode);
    wr(1'b1, 8'h01);
    rd_st(s);
    check("R7 ready after enable", s, 8'h05);
    wr(1'b0, d);
    check("R7 data write clears TxRDY", txrdy, 0);
    bad_i = -1; bad_got = 1'b0; bad_exp = 1'b0;
    for (int i = 0; i < total; i++) begin
      tick();
      got = txd;
      exp = exp_bit(i, f, n, pe, par, d);
      if (got != exp && bad_i < 0) begin
        bad_i = i; bad_got = got; bad_exp = exp;
      end
    end
    n_run++;
    if (bad_i >= 0) begin
      n_fail++;
      $display("FAIL R2 R3 R4 R5 R6 mode=%0h data=%0h tick=%0d actual=%0d expected=%0d",
               mode, d, bad_i, bad_got, bad_exp);
    end
    check("R8 TxEMPTY low during stop", txempty, 0);
    tick();
    rd_st(s);
    check("R8 TxEMPTY after stop end", s, 8'h05);
    check("R6 idle high after frame", txd, 1);
  endtask

  initial begin
    #800000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6 reset idle high", txd, 1);
    rd_st(s);
    check("R7 reset status", s, 8'h04);
    check("R10 reset dtr", dtr_o, 0);

    // R1: first control write is mode (0x4D has bit0 set but must not enable)
    wr(1'b1, 8'h4D);
    rd_st(s);
    check("R1 mode byte not taken as command", s, 8'h04);
    wr(1'b1, 8'h22);
    check("R10 dtr follows bit1", dtr_o, 1);
    check("R10 rts follows bit5", rts_o, 1);
    rd_st(s);
    check("R7 TxRDY needs enable", s, 8'h04);

    // R11: held character waits while disabled
    wr(1'b0, 8'h00);
    begin
      int low = 0;
      for (int i = 0; i < 30; i++) begin
        tick();
        if (txd == 1'b0) low++;
      end
      check("R11 no start while disabled", low, 0);
    end
    rd_st(s);
    check("R11 held char keeps TxEMPTY low", s, 8'h00);
    wr(1'b1, 8'h01);
    check("R10 dtr cleared by command", dtr_o, 0);
    tick();
    check("R11 start after enable", txd, 0);

    // R1: internal reset clears command bits, next write is mode again
    wr(1'b1, 8'h40);
    rd_st(s);
    check("R1 internal reset clears state", s, 8'h04);
    check("R1 idle after internal reset", txd, 1);
    wr(1'b1, 8'h4D);
    rd_st(s);
    check("R1 mode again after internal reset", s, 8'h04);
    wr(1'b1, 8'h03);
    rd_st(s);
    check("R1 later write is command", s, 8'h05);
    check("R10 dtr set", dtr_o, 1);

    // R12: back-to-back frames, x1, 8 bits, no parity, 1 stop
    wr(1'b0, 8'h3C);
    tick();
    check("R12 first start bit", txd, 0);
    wr(1'b0, 8'hC3);
    check("R12 TxRDY low with second char", txrdy, 0);
    begin
      int bad = 0;
      for (int i = 1; i < 10; i++) begin
        tick();
        if (txd != exp_bit(i, 1, 8, 0, 1'b0, 8'h3C)) bad++;
      end
      check("R12 first frame bits", bad, 0);
    end
    tick();
    check("R12 second start with no idle", txd, 0);
    check("R12 TxEMPTY low across frames", txempty, 0);
    tick();
    check("R12 second frame bit0", txd, 1);

    // R9: break holds line low
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h4D);
    wr(1'b1, 8'h09);
    begin
      int high = 0;
      for (int i = 0; i < 5; i++) begin
        tick();
        if (txd) high++;
      end
      check("R9 break holds low", high, 0);
    end
    wr(1'b1, 8'h01);
    check("R9 line high after break cleared", txd, 1);

    // R2..R6 sweep over all factor, length, parity and stop codes
    for (int fs = 1; fs <= 3; fs++)
      for (int len = 0; len <= 3; len++)
        for (int pm = 0; pm <= 2; pm++)
          for (int st = 1; st <= 3; st++)
            run_frame(fs, len, pm, st, 8'hA5 ^ 8'((fs * 36 + len * 9 + pm * 3 + st) * 37));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule